// File: doc/BRIEF.md
# BERT Saturating Bit Counter

This block counts the data bits a bit-error-rate tester has received. A bit-clock enable marks each received bit. The count advances only while the pattern-lock input shows that the tester is synchronized to the incoming pattern. Without lock, the count holds. The counter never wraps. Once every bit is one it stays there, and a sticky overflow flag goes high.

Software restarts a measurement by writing a rising edge on a clear control bit. That edge zeroes the count and drops the overflow flag. The running count is read one byte at a time through a plain combinational read port. The port has an 8-bit address and 8-bit data. The lowest byte of the count sits at address 0xE3, and each following address holds the next higher byte.

Top module: `bert_bit_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count and the overflow flag become zero, so every byte reads 0x00 and `ovf_flag` is 0.
- R2: At each clock edge where `bit_en` and `sync_ok` are both 1 and no clear applies, the count rises by exactly one.
- R3: At a clock edge where `sync_ok` is 0, the count does not change, whatever `bit_en` is.
- R4: At a clock edge where `bit_en` is 0, the count does not change, whatever `sync_ok` is.
- R5: A 0-to-1 change of `clr_ctl` sets the count to zero at the first clock edge where `clr_ctl` is sampled as 1. Keeping `clr_ctl` high afterwards does not clear the count again.
- R6: A 1-to-0 change of `clr_ctl` has no effect on the count.
- R7: When a clear edge and a qualified increment fall on the same clock edge, the count becomes zero.
- R8: When the count is all ones, further qualified increments leave it at all ones.
- R9: `ovf_flag` goes to 1 at the same edge where the count becomes all ones. It then stays 1 until a clear edge, which returns it to 0.
- R10: `rd_data` returns count bits 7:0 at address 0xE3, bits 15:8 at 0xE4, bits 23:16 at 0xE5 and bits 31:24 at 0xE6.
- R11: A read of any address outside 0xE3 to 0xE6 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One received data bit in this cycle |
| sync_ok | input | 1 | Tester is locked to the pattern |
| clr_ctl | input | 1 | Clear control bit; its rising edge restarts the count |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Selected count byte, or 0x00 outside the window |
| ovf_flag | output | 1 | Sticky flag set when the count saturates |

## Verification
The hardest state to reach from the ports is saturation. It would take more than four billion qualified bits at the default width. The bench therefore adds a second instance with a 16-bit count and drives it through 65,535 enables. It checks the last step below saturation, the step into it, several steps held at saturation, and the clear that follows. The full-width instance is counted to 0x00010203, so that each of its four byte addresses returns a distinct value.

// File: rtl/bert_cnt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the bit counter.
// Assumes the read port is byte-wide.
package bert_cnt_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam logic [7:0] DEF_BASE_ADDR = 8'hE3;
endpackage

// File: rtl/bert_clr_edge.sv
`timescale 1ns/1ps
// Module: bert_clr_edge
// Does:    turns a 0-to-1 change of the clear control bit into a one-cycle pulse.
// Assumes: clr_ctl is synchronous to clk. Reset leaves the stored copy at 0,
//          so a bit that is already high right after reset counts as an edge.
module bert_clr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_ctl,
    output logic clr_pulse
);
    logic clr_q;

    // Hold last cycle's value of the control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= clr_ctl;
    end

    // Pulse while the bit is high now but was low before.
    always_comb clr_pulse = clr_ctl & ~clr_q;
endmodule

// File: rtl/bert_sat_counter.sv
`timescale 1ns/1ps
// Module: bert_sat_counter
// Does:    a saturating up-counter with a sticky flag for the all-ones state.
// Assumes: clr has priority over inc. CNT_W is at least 2.
module bert_sat_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX_M1 = CNT_MAX - 1'b1;
    localparam logic [CNT_W-1:0] CNT_ONE    = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             at_max;

    // Detect the saturated value, which blocks further increments.
    always_comb at_max = (cnt_q == CNT_MAX);

    // Update the count and flag: clear first, then a guarded increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (inc && !at_max) begin
            cnt_q <= cnt_q + CNT_ONE;
            if (cnt_q == CNT_MAX_M1) ovf_q <= 1'b1;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        cnt = cnt_q;
        ovf = ovf_q;
    end
endmodule

// File: rtl/bert_byte_rdmux.sv
`timescale 1ns/1ps
// Module: bert_byte_rdmux
// Does:    places the count as consecutive byte registers from BASE_ADDR upward,
//          with the lowest byte first. Any other address reads zero.
// Assumes: CNT_W is a multiple of 8, and the window does not pass the top of
//          the address space.
module bert_byte_rdmux
    import bert_cnt_pkg::*;
#(
    parameter int unsigned      CNT_W     = 32,
    parameter int unsigned      ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(DEF_BASE_ADDR)
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int unsigned NUM_BYTES = CNT_W / BYTE_W;

    logic [BYTE_W-1:0] byte_arr [NUM_BYTES];
    logic [NUM_BYTES-1:0] hit;

    // Cut the count into bytes and decode one address for each byte.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        assign byte_arr[g] = cnt[g*BYTE_W +: BYTE_W];
        assign hit[g]      = (rd_addr == ADDR_W'(int'(BASE_ADDR) + g));
    end

    // Return the byte whose address matches, or zero if none does.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (hit[i]) rd_data = byte_arr[i];
        end
    end
endmodule

// File: rtl/bert_bit_counter.sv
`timescale 1ns/1ps
// Module: bert_bit_counter (top)
// Does:    counts received bits while pattern lock holds, saturates at all ones
//          with a sticky overflow flag, restarts on a rising edge of clr_ctl,
//          and shows the count as byte registers on a read port.
// Assumes: every input is synchronous to clk. rd_data is combinational.
module bert_bit_counter
    import bert_cnt_pkg::*;
#(
    parameter int unsigned       CNT_W     = 32,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(DEF_BASE_ADDR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              sync_ok,
    input  logic              clr_ctl,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_flag
);
    logic             clr_pulse;
    logic             inc_ok;
    logic [CNT_W-1:0] cnt_val;

    // Count only a bit that arrives while the tester is locked.
    always_comb inc_ok = bit_en & sync_ok;

    bert_clr_edge u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_ctl   (clr_ctl),
        .clr_pulse (clr_pulse)
    );

    bert_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_pulse),
        .inc   (inc_ok),
        .cnt   (cnt_val),
        .ovf   (ovf_flag)
    );

    bert_byte_rdmux #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd (
        .cnt     (cnt_val),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/bert_bit_counter_chk.sv
`timescale 1ns/1ps
// Module: bert_bit_counter_chk
// Does:    property checks on the counter. It is attached to every
//          bert_bit_counter through the bind at the end of this file.
// Assumes: it sees the internal count of the top through the bind.
module bert_bit_counter_chk #(
    parameter int unsigned       CNT_W     = 32,
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hE3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              sync_ok,
    input logic              clr_ctl,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [CNT_W-1:0]  cnt,
    input logic              ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam int unsigned      NUM_BYTES = CNT_W / 8;

    logic prev_clr;
    logic edge_now;
    logic out_of_win;

    // Keep the checker's own copy of the clear bit from the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_clr <= 1'b0;
        else        prev_clr <= clr_ctl;
    end

    // Flag a clear edge and an address outside the byte window.
    always_comb begin
        edge_now   = clr_ctl && !prev_clr;
        out_of_win = (int'(rd_addr) < int'(BASE_ADDR)) ||
                     (int'(rd_addr) >= int'(BASE_ADDR) + NUM_BYTES);
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !ovf));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && sync_ok && !edge_now && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

    assert_hold_unqualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bit_en && sync_ok) && !edge_now) |=> $stable(cnt));

    assert_clear_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_now |=> (cnt == '0 && !ovf));

    assert_saturate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !edge_now) |=> (cnt == CNT_MAX));

    assert_flag_matches_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf == (cnt == CNT_MAX));

    assert_outside_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_win |-> (rd_data == 8'h00));
endmodule

bind bert_bit_counter bert_bit_counter_chk #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .sync_ok (sync_ok),
    .clr_ctl (clr_ctl),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .cnt     (cnt_val),
    .ovf     (ovf_flag)
);

// File: tb/bert_bit_counter_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario. dut_i has the full 32-bit width;
// sat_i has a 16-bit width so that saturation can be reached.
module bert_bit_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, sync_ok = 1'b0, clr_ctl = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic ovf_flag;

    logic s_en = 1'b0, s_sync = 1'b0, s_clr = 1'b0;
    logic [7:0] s_addr = 8'h00;
    logic [7:0] s_data;
    logic s_ovf;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bert_bit_counter dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_ok(sync_ok),
        .clr_ctl(clr_ctl), .rd_addr(rd_addr), .rd_data(rd_data), .ovf_flag(ovf_flag)
    );

    bert_bit_counter #(.CNT_W(16)) sat_i (
        .clk(clk), .rst_n(rst_n), .bit_en(s_en), .sync_ok(s_sync),
        .clr_ctl(s_clr), .rd_addr(s_addr), .rd_data(s_data), .ovf_flag(s_ovf)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_byte(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd_count(output logic [31:0] v);
        for (int b = 0; b < 4; b++) begin
            logic [7:0] t;
            rd_byte(8'hE3 + 8'(b), t);
            v[b*8 +: 8] = t;
        end
    endtask

    task automatic rd_sat(output logic [15:0] v);
        s_addr = 8'hE3; #1; v[7:0]  = s_data;
        s_addr = 8'hE4; #1; v[15:8] = s_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_count(v);
        chk("R1 count after reset", v, 32'h0);
        chk("R1 overflow after reset", {31'h0, ovf_flag}, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        sync_ok = 1'b1; bit_en = 1'b1;
        repeat (37) tick();
        bit_en = 1'b0;
        rd_count(v);
        chk("R2 steady count", v, 32'd37);
        for (int i = 0; i < 20; i++) begin
            bit_en = i[0];
            tick();
        end
        bit_en = 1'b0;
        rd_count(v);
        chk("R2 alternating enable", v, 32'd47);
        chk("R2 no overflow", {31'h0, ovf_flag}, 32'h0);
    endtask

    task automatic t_nosync();
        logic [31:0] v;
        sync_ok = 1'b0; bit_en = 1'b1;
        repeat (10) tick();
        rd_count(v);
        chk("R3 hold without lock", v, 32'd47);
        sync_ok = 1'b1; bit_en = 1'b0;
    endtask

    task automatic t_noen();
        logic [31:0] v;
        sync_ok = 1'b1; bit_en = 1'b0;
        repeat (10) tick();
        rd_count(v);
        chk("R4 hold without enable", v, 32'd47);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        bit_en = 1'b0; clr_ctl = 1'b1;
        tick();
        rd_count(v);
        chk("R5 clear on rising edge", v, 32'd0);
        bit_en = 1'b1;
        repeat (5) tick();
        rd_count(v);
        chk("R5 level held clears once", v, 32'd5);
        clr_ctl = 1'b0;
        tick();
        rd_count(v);
        chk("R6 falling edge ignored", v, 32'd6);
        bit_en = 1'b0;
    endtask

    task automatic t_clear_wins();
        logic [31:0] v;
        bit_en = 1'b1; sync_ok = 1'b1; clr_ctl = 1'b1;
        tick();
        clr_ctl = 1'b0; bit_en = 1'b0;
        rd_count(v);
        chk("R7 clear beats increment", v, 32'd0);
    endtask

    task automatic t_outside();
        logic [7:0] b;
        bit_en = 1'b1;
        repeat (3) tick();
        bit_en = 1'b0;
        rd_byte(8'hE2, b); chk("R11 addr E2", {24'h0, b}, 32'h0);
        rd_byte(8'hE7, b); chk("R11 addr E7", {24'h0, b}, 32'h0);
        rd_byte(8'h00, b); chk("R11 addr 00", {24'h0, b}, 32'h0);
        rd_byte(8'hFF, b); chk("R11 addr FF", {24'h0, b}, 32'h0);
        rd_byte(8'hE3, b); chk("R10 low byte", {24'h0, b}, 32'h3);
    endtask

    task automatic t_bytes();
        logic [7:0] b;
        clr_ctl = 1'b1; tick();
        clr_ctl = 1'b0; tick();
        bit_en = 1'b1;
        repeat (66051) tick();
        bit_en = 1'b0;
        rd_byte(8'hE3, b); chk("R10 byte E3", {24'h0, b}, 32'h03);
        rd_byte(8'hE4, b); chk("R10 byte E4", {24'h0, b}, 32'h02);
        rd_byte(8'hE5, b); chk("R10 byte E5", {24'h0, b}, 32'h01);
        rd_byte(8'hE6, b); chk("R10 byte E6", {24'h0, b}, 32'h00);
        chk("R9 no overflow below max", {31'h0, ovf_flag}, 32'h0);
    endtask

    task automatic t_saturate();
        logic [15:0] v;
        s_sync = 1'b1; s_en = 1'b1;
        repeat (65534) tick();
        s_en = 1'b0;
        rd_sat(v);
        chk("R2 one below max", {16'h0, v}, 32'hFFFE);
        chk("R9 flag low below max", {31'h0, s_ovf}, 32'h0);
        s_en = 1'b1;
        tick();
        rd_sat(v);
        chk("R8 reaches all ones", {16'h0, v}, 32'hFFFF);
        chk("R9 flag rises at max", {31'h0, s_ovf}, 32'h1);
        repeat (4) tick();
        rd_sat(v);
        chk("R8 holds at all ones", {16'h0, v}, 32'hFFFF);
        chk("R9 flag sticky", {31'h0, s_ovf}, 32'h1);
        s_en = 1'b0; s_clr = 1'b1;
        tick();
        s_clr = 1'b0;
        rd_sat(v);
        chk("R9 clear after saturation", {16'h0, v}, 32'h0);
        chk("R9 flag cleared by edge", {31'h0, s_ovf}, 32'h0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_nosync();
        t_noen();
        t_clear();
        t_clear_wins();
        t_outside();
        t_bytes();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule